// File: doc/BRIEF.md
# I2C Passive Bus Monitor with Event Tagging

This block listens to the two wires of an I2C bus without taking part in any transfer. It records every byte that crosses the bus, address bytes included. Each byte is stored together with three tags. One tag marks a byte that follows a start from an idle bus. One marks a byte that follows a repeated start. One marks a byte that the receiver did not acknowledge. The block never drives SDA and applies no address filter.

One capture word is held for a reader, with a ready flag and a sticky overflow flag. The block also reports whether a transaction is in progress, and raises a sticky idle flag when a stop returns the bus to rest.

An optional stretch mode prevents data loss. In that mode the block holds SCL low after the acknowledge bit of a byte that has not been read yet, and lets SCL go once the reader has taken the word. Both bus lines pass through a two-flop synchroniser and are judged from the system clock.

Top module: `i2c_bus_monitor`

## Requirements
- R1: The capture word carries the data byte in bits 7:0. The byte is assembled MSB first from SDA sampled at the first eight SCL rising edges after a start.
- R2: Bit 8 (start tag) is 1 only for the first byte after a start seen while the bus was idle, meaning after reset or after a stop. Later bytes in the same transaction have both start tags at 0.
- R3: Bit 9 (repeated-start tag) is 1 only for the first byte after a start that arrived with no stop since the previous start. In that case bit 8 is 0.
- R4: Bit 10 (NACK tag) equals the SDA level at the ninth SCL rising edge of the byte, so 1 means not acknowledged.
- R5: `cap_ready` goes high when a capture word completes. A one-cycle `rd_strobe` clears it. If a word completes in the same cycle as the read, `cap_ready` stays high and holds the new word.
- R6: If a word completes while `cap_ready` is high and no read occurs in that cycle, `ovf_flag` is set and the new word replaces the old one. `ovf_flag` stays set until a pulse on `ovf_clr`.
- R7: `bus_active` is high from a start condition (SDA falling while SCL is high) until a stop condition (SDA rising while SCL is high).
- R8: `idle_flag` is set by a stop condition and stays set until a pulse on `idle_clr`.
- R9: While `mon_en` is low, no word is captured, `bus_active` stays low and SCL is never held.
- R10: When `stretch_en` is high, `scl_hold` goes high once SCL is low after the acknowledge bit of a byte whose word is still unread. It falls after that word is read, so no overflow occurs.
- R11: After reset, all flags, `scl_hold` and the capture word are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitoring enable |
| stretch_en | input | 1 | Allow SCL holding to avoid overflow |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| rd_strobe | input | 1 | One-cycle pulse: reader takes the capture word |
| ovf_clr | input | 1 | One-cycle pulse: clear the overflow flag |
| idle_clr | input | 1 | One-cycle pulse: clear the idle flag |
| scl_hold | output | 1 | 1 = pull SCL low (open-drain enable) |
| cap_word | output | 11 | {nack, repeated start, start, data[7:0]} |
| cap_ready | output | 1 | Unread capture word present |
| ovf_flag | output | 1 | Sticky: a word was overwritten unread |
| bus_active | output | 1 | Transaction in progress |
| idle_flag | output | 1 | Sticky: a stop was seen |

## Verification
The assertions assume that each SCL and SDA level lasts several system clocks. They also assume that SDA changes only while SCL is low, except when forming a start or a stop, so the synchronised edges can be judged one at a time.

The stimulus meets these assumptions. The bench's bus master holds every level for six clocks. It waits for the SCL line to actually go high before timing the high phase. It never tries to stop while SCL is being held.

Random transactions vary the byte values, the acknowledge levels, the transfer lengths and where repeated starts fall. Directed cases cover overflow, stretching and the disabled state.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 3;

  typedef struct packed {
    logic              nack;
    logic              rstart;
    logic              start;
    logic [DATA_W-1:0] data;
  } cap_word_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Idle I2C lines rest high, so the chain resets to 1.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_mon_framer.sv
module i2c_mon_framer
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      scl_rise,
  input  logic      start_ev,
  input  logic      stop_ev,
  input  logic      sda_s,
  output logic      emit,
  output cap_word_t word,
  output logic      active
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              in_frame;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic              tag_st, tag_rs;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active   <= 1'b0;
      in_frame <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      tag_st   <= 1'b0;
      tag_rs   <= 1'b0;
      emit     <= 1'b0;
      word     <= '0;
    end else begin
      emit <= 1'b0;
      if (start_ev) begin
        in_frame <= 1'b1;
        bitcnt   <= '0;
        tag_st   <= ~active;
        tag_rs   <= active;
        active   <= 1'b1;
      end else if (stop_ev) begin
        active   <= 1'b0;
        in_frame <= 1'b0;
        tag_st   <= 1'b0;
        tag_rs   <= 1'b0;
      end else if (scl_rise && in_frame) begin
        if (bitcnt == CNT_W'(DATA_W)) begin
          word   <= '{nack: sda_s, rstart: tag_rs, start: tag_st, data: shreg};
          emit   <= 1'b1;
          bitcnt <= '0;
          tag_st <= 1'b0;
          tag_rs <= 1'b0;
        end else begin
          shreg  <= {shreg[DATA_W-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  // R3: a word never carries both start tags
  assert_one_start_tag_R3: assert property (@(posedge clk) disable iff (rst)
    emit |-> !(word.start && word.rstart));
  // R7: a stop ends the transaction
  assert_stop_clears_active_R7: assert property (@(posedge clk) disable iff (rst)
    (en && stop_ev && !start_ev) |=> !active);
endmodule

// File: rtl/i2c_mon_hold.sv
module i2c_mon_hold
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      emit,
  input  cap_word_t word_in,
  input  logic      rd,
  input  logic      ovf_clr,
  output cap_word_t word_q,
  output logic      ready,
  output logic      ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      ready  <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (emit) begin
        word_q <= word_in;
        ready  <= 1'b1;
      end else if (rd) begin
        ready  <= 1'b0;
      end
      if (emit && ready && !rd) ovf <= 1'b1;
      else if (ovf_clr)         ovf <= 1'b0;
    end
  end

  assert_ovf_on_lost_R6: assert property (@(posedge clk) disable iff (rst)
    (emit && ready && !rd) |=> ovf);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd && !emit) |=> !ready);
  assert_emit_sets_R5: assert property (@(posedge clk) disable iff (rst)
    emit |=> ready);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mon_en,
  input  logic              stretch_en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              rd_strobe,
  input  logic              ovf_clr,
  input  logic              idle_clr,
  output logic              scl_hold,
  output logic [WORD_W-1:0] cap_word,
  output logic              cap_ready,
  output logic              ovf_flag,
  output logic              bus_active,
  output logic              idle_flag
);
  logic [1:0] sync_q;
  logic       scl_s, sda_s;
  logic       scl_rise, start_ev, stop_ev;
  logic       emit;
  cap_word_t  fr_word, hold_word;
  logic       post_ack;

  i2c_mon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2c_mon_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_mon_framer u_framer (
    .clk(clk), .rst(rst), .en(mon_en), .scl_rise(scl_rise),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
    .emit(emit), .word(fr_word), .active(bus_active)
  );

  i2c_mon_hold u_hold (
    .clk(clk), .rst(rst), .emit(emit), .word_in(fr_word), .rd(rd_strobe),
    .ovf_clr(ovf_clr), .word_q(hold_word), .ready(cap_ready), .ovf(ovf_flag)
  );
  assign cap_word = hold_word;

  // Stretch control: armed after a byte's ACK, engaged only while SCL is low.
  always_ff @(posedge clk) begin
    if (rst || !mon_en) begin
      post_ack <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      if (emit)                                post_ack <= 1'b1;
      else if (rd_strobe || start_ev || stop_ev) post_ack <= 1'b0;
      scl_hold <= stretch_en && post_ack && cap_ready && !rd_strobe
                  && (scl_hold || !scl_s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     idle_flag <= 1'b0;
    else if (mon_en && stop_ev)  idle_flag <= 1'b1;
    else if (idle_clr)           idle_flag <= 1'b0;
  end

  assert_hold_needs_stretch_R10: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> $past(stretch_en && cap_ready));
  assert_no_capture_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> !$rose(cap_ready));
  assert_idle_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (idle_flag && !idle_clr) |=> idle_flag);
endmodule

// File: tb/i2c_bus_monitor_tb.sv
module i2c_bus_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mon_en = 1'b0, stretch_en = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic rd_strobe = 1'b0, ovf_clr = 1'b0, idle_clr = 1'b0;
  logic scl_hold, cap_ready, ovf_flag, bus_active, idle_flag;
  logic [10:0] cap_word;
  logic scl_line;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign scl_line = scl_drv & ~scl_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_monitor u_dut (
    .clk(clk), .rst(rst), .mon_en(mon_en), .stretch_en(stretch_en),
    .scl_in(scl_line), .sda_in(sda_drv), .rd_strobe(rd_strobe),
    .ovf_clr(ovf_clr), .idle_clr(idle_clr), .scl_hold(scl_hold),
    .cap_word(cap_word), .cap_ready(cap_ready), .ovf_flag(ovf_flag),
    .bus_active(bus_active), .idle_flag(idle_flag)
  );

  function automatic logic [10:0] exp_word(logic [7:0] d, logic nack, logic st, logic rs);
    return {nack, rs, st, d};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; wclk(1); rd_strobe = 1'b0;
  endtask

  task automatic bus_start();
    sda_drv = 1'b0; wclk(HALF); scl_drv = 1'b0; wclk(HALF);
  endtask

  task automatic bus_rstart();
    sda_drv = 1'b1; wclk(HALF); scl_drv = 1'b1; wclk(HALF);
    sda_drv = 1'b0; wclk(HALF); scl_drv = 1'b0; wclk(HALF);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wclk(HALF); scl_drv = 1'b1; wclk(1);
    while (!scl_line) wclk(1);
    wclk(HALF); sda_drv = 1'b1; wclk(HALF);
  endtask

  task automatic send_bit(logic b);
    sda_drv = b; wclk(HALF); scl_drv = 1'b1; wclk(1);
    while (!scl_line) wclk(1);
    wclk(HALF); scl_drv = 1'b0; wclk(HALF);
  endtask

  task automatic send_byte(logic [7:0] d, logic nack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(nack);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    wclk(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin : stim
    logic [7:0] d;
    logic nk;
    logic st, rs;
    void'($urandom(32'd1234));
    wclk(5);
    rst = 1'b0;
    wclk(2);
    // R11 reset state
    check("R11 ready", cap_ready, 0);
    check("R11 ovf", ovf_flag, 0);
    check("R11 active", bus_active, 0);
    check("R11 idle", idle_flag, 0);
    check("R11 hold", scl_hold, 0);
    check("R11 word", cap_word, 0);

    mon_en = 1'b1;
    wclk(4);
    // directed: start, two bytes, repeated start, stop
    bus_start();
    check("R7 active after start", bus_active, 1);
    send_byte(8'hA4, 1'b0);
    check("R5 ready set", cap_ready, 1);
    check("R1 R2 first word", cap_word, exp_word(8'hA4, 0, 1, 0));
    pulse_rd();
    check("R5 read clears ready", cap_ready, 0);
    send_byte(8'h5B, 1'b1);
    check("R4 nack word", cap_word, exp_word(8'h5B, 1, 0, 0));
    pulse_rd();
    bus_rstart();
    send_byte(8'h33, 1'b0);
    check("R3 repeated start word", cap_word, exp_word(8'h33, 0, 0, 1));
    pulse_rd();
    check("R8 idle low before stop", idle_flag, 0);
    bus_stop();
    wclk(4);
    check("R7 active after stop", bus_active, 0);
    check("R8 idle set", idle_flag, 1);
    wclk(20);
    check("R8 idle sticky", idle_flag, 1);
    idle_clr = 1'b1; wclk(1); idle_clr = 1'b0; wclk(1);
    check("R8 idle cleared", idle_flag, 0);

    // overflow without stretching
    bus_start();
    send_byte(8'hC1, 1'b0);
    check("R6 no ovf yet", ovf_flag, 0);
    send_byte(8'h7E, 1'b0);
    check("R6 ovf set", ovf_flag, 1);
    check("R6 new word kept", cap_word, exp_word(8'h7E, 0, 0, 0));
    bus_stop();
    wclk(20);
    check("R6 ovf sticky", ovf_flag, 1);
    ovf_clr = 1'b1; wclk(1); ovf_clr = 1'b0; wclk(1);
    check("R6 ovf cleared", ovf_flag, 0);
    pulse_rd();
    idle_clr = 1'b1; wclk(1); idle_clr = 1'b0;

    // stretch mode
    stretch_en = 1'b1;
    bus_start();
    send_byte(8'h96, 1'b0);
    check("R10 hold engaged", scl_hold, 1);
    fork
      send_byte(8'h3C, 1'b1);
      begin
        wclk(40);
        check("R10 hold still on", scl_hold, 1);
        check("R10 scl line low", scl_line, 0);
        check("R10 old word kept", cap_word, exp_word(8'h96, 0, 1, 0));
        pulse_rd();
        wclk(2);
        check("R10 hold released", scl_hold, 0);
      end
    join
    check("R10 second word", cap_word, exp_word(8'h3C, 1, 0, 0));
    check("R10 no overflow", ovf_flag, 0);
    pulse_rd();
    bus_stop();
    stretch_en = 1'b0;
    wclk(4);

    // R9 disabled
    mon_en = 1'b0;
    wclk(2);
    bus_start();
    check("R9 inactive when off", bus_active, 0);
    send_byte(8'hE7, 1'b0);
    check("R9 no capture", cap_ready, 0);
    bus_stop();
    mon_en = 1'b1;
    wclk(4);
    idle_clr = 1'b1; wclk(1); idle_clr = 1'b0;

    // random transactions
    for (int t = 0; t < 25; t++) begin
      bus_start();
      st = 1'b1; rs = 1'b0;
      for (int b = 0; b < 1 + int'($urandom_range(2)); b++) begin
        if (b > 0 && $urandom_range(3) == 0) begin
          bus_rstart();
          st = 1'b0; rs = 1'b1;
        end
        d  = 8'($urandom);
        nk = 1'($urandom);
        send_byte(d, nk);
        check("R1 R4 random ready", cap_ready, 1);
        check("R1 R2 R3 R4 random word", cap_word, exp_word(d, nk, st, rs));
        check("R7 random active", bus_active, 1);
        pulse_rd();
        st = 1'b0; rs = 1'b0;
      end
      bus_stop();
      wclk(4);
      check("R7 random idle", bus_active, 0);
      check("R6 random no ovf", ovf_flag, 0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule